// File: doc/BRIEF.md
# Doorbell Mailbox Register Interface

This block is the host-visible mailbox register window of a memory-expansion device. A simple register bus issues reads and writes of 1, 2, 4 or 8 bytes, naming a byte address and a size code. The block keeps a small register header followed by a byte-addressable payload buffer. Host software places a command in the command register and its arguments in the payload, then sets the doorbell bit in the control register. The block then hands a single-cycle request to an external command engine.

Each header register has its own write rule by access width. The payload area takes writes of any legal size and stores exactly the addressed bytes. The engine later clears the doorbell and writes the status register through a private side port. The host cannot write either status register.

Read and write data are right-justified on the bus: byte k of an access travels on bits [8k+7:8k], and the byte at the lowest address is byte 0 (little-endian). A read answers with `bus_rvalid` two cycles after the request. The error flag for an access is raised one cycle after the request.

Top module: `mbox_regs`

## Requirements
- R1: The size code `bus_size` means 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes and 3 = 8 bytes. An access whose address is not a multiple of its size is refused: a refused write changes nothing, and a refused read returns zero. Either one raises `bus_err` for exactly the cycle after the request.
- R2: A legal read returns the stored bytes little-endian and right-justified in `bus_rdata`, with `bus_rvalid` high for the single cycle two clock edges after the request.
- R3: Addresses 0x020 through 0x81F form a 2048-byte payload buffer. A legal write of any size there stores exactly the addressed bytes and leaves the neighbouring bytes unchanged, with no error.
- R4: The capability register (offset 0x00) and the control register (offset 0x04) are written only by 4-byte writes at their own offsets. The 64-bit command register (offset 0x08) is written only by 8-byte writes at offset 0x08.
- R5: An 8-byte write at the status register (offset 0x10) or at the background-status register (offset 0x18) is ignored without an error.
- R6: Any other write below offset 0x020 is dropped, leaving all registers unchanged, and raises `bus_err` for one cycle.
- R7: After an accepted write (header or payload), if bit 0 of the control register (the doorbell) is 1, `eng_req` is high for exactly the cycle after that write.
- R8: While the doorbell stays set, further accepted writes do not raise `eng_req` again. A pulse on `eng_clr_db` clears the doorbell bit, and after that a write that sets it raises `eng_req` anew.
- R9: A pulse on `eng_sts_we` loads `eng_sts` into the status register, which the host then reads at offset 0x10.
- R10: After reset, the capability register reads 0x0000000B: bits [4:0] hold the payload size exponent 11 (2048 bytes), bit 5 (interrupt support) is 0 and bit 6 (background-command support) is 0. The background-status register always reads zero, and `eng_req` and `bus_err` are low.
- R11: Any access at address 0x820 or above is refused. A write there is dropped, a read returns zero, and both raise `bus_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_size | input | 2 | Access size code (log2 of bytes) |
| bus_wdata | input | 64 | Right-justified write data |
| bus_rvalid | output | 1 | Read data valid |
| bus_rdata | output | 64 | Right-justified read data |
| bus_err | output | 1 | Refused-access pulse |
| eng_req | output | 1 | Process request to the command engine |
| eng_clr_db | input | 1 | Engine clears the doorbell |
| eng_sts_we | input | 1 | Engine writes the status register |
| eng_sts | input | 64 | Status value from the engine |

## Verification
The assertions check on every cycle that a request pulse only appears while the doorbell is set and is not repeated while it stays set. They also check that host writes aimed at the status register, and any write other than an 8-byte write at the command offset, leave those registers unchanged. In addition, they check that read-valid and error pulses only follow a real request at the correct latency. The bench scenarios are the only place where the byte-exact merging of narrow payload writes, the width rules of each header register, the refusal of misaligned and out-of-range accesses and the re-arming of the doorbell after the engine clears it become visible.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  typedef enum logic [2:0] {
    RG_CAP  = 3'd0,
    RG_CTRL = 3'd1,
    RG_CMD  = 3'd2,
    RG_RO   = 3'd3,
    RG_PAY  = 3'd4,
    RG_BAD  = 3'd5
  } region_e;

  localparam int unsigned OFF_CAP  = 0;
  localparam int unsigned OFF_CTRL = 4;
  localparam int unsigned OFF_CMD  = 8;
  localparam int unsigned OFF_STS  = 16;
  localparam int unsigned OFF_BG   = 24;
  localparam int unsigned DB_BIT   = 0;

  function automatic logic [7:0] size_strb(input logic [1:0] sz);
    case (sz)
      2'd0:    return 8'h01;
      2'd1:    return 8'h03;
      2'd2:    return 8'h0F;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [63:0] size_mask64(input logic [1:0] sz);
    case (sz)
      2'd0:    return 64'h0000_0000_0000_00FF;
      2'd1:    return 64'h0000_0000_0000_FFFF;
      2'd2:    return 64'h0000_0000_FFFF_FFFF;
      default: return 64'hFFFF_FFFF_FFFF_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/mbox_decode.sv
module mbox_decode
  import mbox_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned PAY_OFF   = 32,
  parameter int unsigned PAY_BYTES = 2048
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output logic              aligned,
  output logic              in_range,
  output logic              pay_hit,
  output region_e           wr_region
);
  localparam logic [ADDR_W:0]   PAY_END_A = (ADDR_W+1)'(PAY_OFF + PAY_BYTES);
  localparam logic [ADDR_W-1:0] PAY_OFF_A = ADDR_W'(PAY_OFF);

  logic [2:0] amask;

  always_comb begin
    case (size)
      2'd0:    amask = 3'b000;
      2'd1:    amask = 3'b001;
      2'd2:    amask = 3'b011;
      default: amask = 3'b111;
    endcase
    aligned  = (addr[2:0] & amask) == 3'b000;
    in_range = {1'b0, addr} < PAY_END_A;
    pay_hit  = in_range && (addr >= PAY_OFF_A);

    wr_region = RG_BAD;
    if (aligned && in_range) begin
      if (pay_hit)
        wr_region = RG_PAY;
      else if (size == 2'd2 && addr == ADDR_W'(OFF_CAP))
        wr_region = RG_CAP;
      else if (size == 2'd2 && addr == ADDR_W'(OFF_CTRL))
        wr_region = RG_CTRL;
      else if (size == 2'd3 && addr == ADDR_W'(OFF_CMD))
        wr_region = RG_CMD;
      else if (size == 2'd3 && (addr == ADDR_W'(OFF_STS) || addr == ADDR_W'(OFF_BG)))
        wr_region = RG_RO;
    end
  end

endmodule

// File: rtl/mbox_payload_ram.sv
module mbox_payload_ram #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic             re,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       strb,
  input  logic [63:0]      wdata,
  output logic [63:0]      rdata
);
  logic [63:0] mem [DEPTH];

  for (genvar b = 0; b < 8; b++) begin : g_lane
    always_ff @(posedge clk) begin
      if (we && strb[b])
        mem[idx][8*b +: 8] <= wdata[8*b +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (re)
      rdata <= mem[idx];
  end

endmodule

// File: rtl/mbox_hdr_regs.sv
module mbox_hdr_regs
  import mbox_pkg::*;
#(
  parameter int unsigned CAP_EXP = 11
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        host_wr,
  input  region_e     region,
  input  logic [63:0] wdata,
  input  logic        eng_clr,
  input  logic        eng_sts_we,
  input  logic [63:0] eng_sts,
  input  logic        snap_en,
  input  logic [1:0]  snap_sel,
  output logic [63:0] snap_q,
  output logic        proc_req
);
  localparam logic [31:0] CAP_RST = 32'(CAP_EXP) & 32'h0000_001F;

  logic [31:0] cap, ctrl, ctrl_nx;
  logic [63:0] cmd, sts;
  logic        sent, sent_af, sent_nx, acc_wr, fire;

  always_comb begin
    acc_wr  = host_wr && region != RG_BAD && region != RG_RO;
    ctrl_nx = ctrl;
    if (eng_clr)
      ctrl_nx[DB_BIT] = 1'b0;
    if (acc_wr && region == RG_CTRL)
      ctrl_nx = wdata[31:0];
    sent_af = sent && !eng_clr;
    fire    = acc_wr && ctrl_nx[DB_BIT] && !sent_af;
    sent_nx = ctrl_nx[DB_BIT] && (sent_af || fire);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cap      <= CAP_RST;
      ctrl     <= '0;
      cmd      <= '0;
      sts      <= '0;
      sent     <= 1'b0;
      proc_req <= 1'b0;
      snap_q   <= '0;
    end else begin
      if (acc_wr && region == RG_CAP)
        cap <= wdata[31:0];
      if (acc_wr && region == RG_CMD)
        cmd <= wdata;
      if (eng_sts_we)
        sts <= eng_sts;
      ctrl     <= ctrl_nx;
      sent     <= sent_nx;
      proc_req <= fire;
      if (snap_en) begin
        case (snap_sel)
          2'd0:    snap_q <= {ctrl, cap};
          2'd1:    snap_q <= cmd;
          2'd2:    snap_q <= sts;
          default: snap_q <= '0;
        endcase
      end
    end
  end

  AST_REQ_WITH_DOORBELL: assert property (@(posedge clk) disable iff (rst)
    proc_req |-> ctrl[DB_BIT]); // R7

  AST_NO_REISSUE: assert property (@(posedge clk) disable iff (rst)
    (proc_req && !eng_clr && !(host_wr && region == RG_CTRL)) |=> !proc_req); // R8

  AST_STATUS_HOST_RO: assert property (@(posedge clk) disable iff (rst)
    (host_wr && region == RG_RO && !eng_sts_we) |=> $stable(sts)); // R5

  AST_CMD_ONLY_WIDE: assert property (@(posedge clk) disable iff (rst)
    !(host_wr && region == RG_CMD) |=> $stable(cmd)); // R4

endmodule

// File: rtl/mbox_regs.sv
module mbox_regs
  import mbox_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned PAY_OFF   = 32,
  parameter int unsigned PAY_BYTES = 2048
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [63:0]       bus_wdata,
  output logic              bus_rvalid,
  output logic [63:0]       bus_rdata,
  output logic              bus_err,
  output logic              eng_req,
  input  logic              eng_clr_db,
  input  logic              eng_sts_we,
  input  logic [63:0]       eng_sts
);
  localparam int unsigned PAY_WORDS = PAY_BYTES / 8;
  localparam int unsigned IDX_W     = $clog2(PAY_WORDS);
  localparam int unsigned CAP_EXP   = $clog2(PAY_BYTES);
  localparam logic [ADDR_W-1:0] PAY_OFF_A = ADDR_W'(PAY_OFF);

  logic        aligned, in_range, pay_hit, rd_ok;
  region_e     wr_region;
  logic [2:0]  lane;
  logic [7:0]  strb;
  logic [63:0] wlane, ram_q, hdr_q, word, shifted;
  logic [IDX_W-1:0] idx;
  logic        ram_we, ram_re, host_wr, rd_req;
  logic        s1_valid, s1_ok, s1_pay;
  logic [2:0]  s1_lane;
  logic [1:0]  s1_size;

  mbox_decode #(.ADDR_W(ADDR_W), .PAY_OFF(PAY_OFF), .PAY_BYTES(PAY_BYTES)) u_dec (
    .addr(bus_addr), .size(bus_size), .aligned(aligned), .in_range(in_range),
    .pay_hit(pay_hit), .wr_region(wr_region)
  );

  always_comb begin
    lane    = bus_addr[2:0];
    strb    = size_strb(bus_size) << lane;
    wlane   = bus_wdata << {lane, 3'b000};
    idx     = IDX_W'((bus_addr - PAY_OFF_A) >> 3);
    rd_ok   = aligned && in_range;
    host_wr = bus_req && bus_we;
    rd_req  = bus_req && !bus_we;
    ram_we  = host_wr && wr_region == RG_PAY;
    ram_re  = rd_req && pay_hit && rd_ok;
  end

  mbox_payload_ram #(.DEPTH(PAY_WORDS), .IDX_W(IDX_W)) u_ram (
    .clk(clk), .we(ram_we), .re(ram_re), .idx(idx), .strb(strb),
    .wdata(wlane), .rdata(ram_q)
  );

  mbox_hdr_regs #(.CAP_EXP(CAP_EXP)) u_hdr (
    .clk(clk), .rst(rst), .host_wr(host_wr), .region(wr_region), .wdata(bus_wdata),
    .eng_clr(eng_clr_db), .eng_sts_we(eng_sts_we), .eng_sts(eng_sts),
    .snap_en(rd_req), .snap_sel(bus_addr[4:3]), .snap_q(hdr_q), .proc_req(eng_req)
  );

  always_comb begin
    word    = s1_pay ? ram_q : hdr_q;
    shifted = word >> {s1_lane, 3'b000};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid   <= 1'b0;
      s1_ok      <= 1'b0;
      s1_pay     <= 1'b0;
      s1_lane    <= '0;
      s1_size    <= '0;
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
      bus_err    <= 1'b0;
    end else begin
      s1_valid   <= rd_req;
      s1_ok      <= rd_ok;
      s1_pay     <= pay_hit;
      s1_lane    <= lane;
      s1_size    <= bus_size;
      bus_rvalid <= s1_valid;
      bus_rdata  <= s1_ok ? (shifted & size_mask64(s1_size)) : 64'd0;
      bus_err    <= bus_req && (bus_we ? (wr_region == RG_BAD) : !rd_ok);
    end
  end

  AST_RVALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    bus_rvalid |-> $past(bus_req && !bus_we, 2)); // R2

  AST_ERR_FROM_REQ: assert property (@(posedge clk) disable iff (rst)
    bus_err |-> $past(bus_req)); // R6

endmodule

// File: tb/tb_mbox_regs.sv
module tb_mbox_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [1:0]  bus_size = '0;
  logic [63:0] bus_wdata = '0;
  logic        bus_rvalid, bus_err, eng_req;
  logic [63:0] bus_rdata;
  logic        eng_clr_db = 1'b0, eng_sts_we = 1'b0;
  logic [63:0] eng_sts = '0;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  mbox_regs dut (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
    .bus_rdata(bus_rdata), .bus_err(bus_err), .eng_req(eng_req),
    .eng_clr_db(eng_clr_db), .eng_sts_we(eng_sts_we), .eng_sts(eng_sts)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [11:0] a, input logic [1:0] sz, input logic [63:0] d,
                          output logic err, output logic req);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_size = sz; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
    err = bus_err; req = eng_req;
  endtask

  task automatic do_read(input logic [11:0] a, input logic [1:0] sz,
                         output logic [63:0] d, output logic err, output logic vld);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a; bus_size = sz;
    @(negedge clk);
    bus_req = 1'b0;
    err = bus_err;
    @(negedge clk);
    d = bus_rdata; vld = bus_rvalid;
  endtask

  task automatic t_reset();
    logic [63:0] d; logic e, v;
    check("R10 eng_req after reset", 64'(eng_req), 64'd0);
    check("R10 bus_err after reset", 64'(bus_err), 64'd0);
    do_read(12'h000, 2'd2, d, e, v);
    check("R10 capability reset value", d, 64'h0000_000B);
    check("R2 rvalid on read", 64'(v), 64'd1);
    do_read(12'h018, 2'd3, d, e, v);
    check("R10 background status zero", d, 64'd0);
  endtask

  task automatic t_payload();
    logic [63:0] d; logic e, v, r;
    do_write(12'h020, 2'd3, 64'h1122_3344_5566_7788, e, r);
    check("R3 8-byte payload write no error", 64'(e), 64'd0);
    do_write(12'h023, 2'd0, 64'hFFFF_FFFF_FFFF_FFAA, e, r);
    do_read(12'h020, 2'd3, d, e, v);
    check("R3 byte merge", d, 64'h1122_3344_AA66_7788);
    do_write(12'h026, 2'd1, 64'h0000_0000_0000_BEEF, e, r);
    do_read(12'h024, 2'd2, d, e, v);
    check("R2 4-byte read little-endian", d, 64'h0000_0000_BEEF_3344);
    do_read(12'h021, 2'd0, d, e, v);
    check("R2 1-byte read", d, 64'h77);
    do_write(12'h81F, 2'd0, 64'h5A, e, r);
    do_read(12'h81F, 2'd0, d, e, v);
    check("R3 last payload byte", d, 64'h5A);
    do_read(12'h021, 2'd1, d, e, v);
    check("R1 misaligned read error", 64'(e), 64'd1);
    check("R1 misaligned read data zero", d, 64'd0);
    do_write(12'h022, 2'd2, 64'h0, e, r);
    check("R1 misaligned write error", 64'(e), 64'd1);
    do_read(12'h020, 2'd3, d, e, v);
    check("R1 misaligned write dropped", d, 64'hBEEF_3344_AA66_7788);
  endtask

  task automatic t_header();
    logic [63:0] d; logic e, v, r;
    do_write(12'h000, 2'd2, 64'h0000_1234, e, r);
    check("R4 capability 4-byte write no error", 64'(e), 64'd0);
    do_read(12'h000, 2'd2, d, e, v);
    check("R4 capability written", d, 64'h0000_1234);
    do_write(12'h008, 2'd3, 64'hCAFE_F00D_1234_5678, e, r);
    do_read(12'h008, 2'd3, d, e, v);
    check("R4 command 8-byte write", d, 64'hCAFE_F00D_1234_5678);
    do_write(12'h008, 2'd2, 64'h0, e, r);
    check("R6 4-byte command write error", 64'(e), 64'd1);
    do_read(12'h008, 2'd3, d, e, v);
    check("R6 command unchanged", d, 64'hCAFE_F00D_1234_5678);
    do_write(12'h000, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, e, r);
    check("R6 8-byte write at 0 error", 64'(e), 64'd1);
    check("R6 no request from dropped write", 64'(r), 64'd0);
    do_write(12'h004, 2'd1, 64'h1, e, r);
    check("R6 2-byte control write error", 64'(e), 64'd1);
    do_read(12'h000, 2'd3, d, e, v);
    check("R6 header unchanged", d, 64'h0000_0000_0000_1234);
    do_write(12'h010, 2'd3, 64'h55, e, r);
    check("R5 status write no error", 64'(e), 64'd0);
    do_read(12'h010, 2'd3, d, e, v);
    check("R5 status unchanged", d, 64'd0);
    do_write(12'h018, 2'd3, 64'h77, e, r);
    check("R5 bg status write no error", 64'(e), 64'd0);
    do_read(12'h018, 2'd3, d, e, v);
    check("R5 bg status still zero", d, 64'd0);
  endtask

  task automatic t_range();
    logic [63:0] d; logic e, v, r;
    do_write(12'h820, 2'd0, 64'h1, e, r);
    check("R11 out-of-range write error", 64'(e), 64'd1);
    do_read(12'h820, 2'd0, d, e, v);
    check("R11 out-of-range read error", 64'(e), 64'd1);
    check("R11 out-of-range read zero", d, 64'd0);
  endtask

  task automatic t_doorbell();
    logic [63:0] d; logic e, v, r;
    do_write(12'h030, 2'd0, 64'h9, e, r);
    check("R7 no request with doorbell clear", 64'(r), 64'd0);
    do_write(12'h004, 2'd2, 64'h1, e, r);
    check("R7 doorbell raises request", 64'(r), 64'd1);
    @(negedge clk);
    check("R7 request lasts one cycle", 64'(eng_req), 64'd0);
    do_write(12'h031, 2'd0, 64'h3, e, r);
    check("R8 no reissue while set", 64'(r), 64'd0);
    do_write(12'h004, 2'd2, 64'h1, e, r);
    check("R8 no reissue on rewrite", 64'(r), 64'd0);
    @(negedge clk); eng_clr_db = 1'b1;
    @(negedge clk); eng_clr_db = 1'b0;
    do_read(12'h004, 2'd2, d, e, v);
    check("R8 engine clears doorbell", d, 64'd0);
    do_write(12'h032, 2'd0, 64'h4, e, r);
    check("R8 no request after clear", 64'(r), 64'd0);
    do_write(12'h004, 2'd2, 64'h1, e, r);
    check("R8 request re-armed", 64'(r), 64'd1);
    @(negedge clk);
    eng_sts_we = 1'b1; eng_sts = 64'h0000_0001_0000_00A5;
    @(negedge clk);
    eng_sts_we = 1'b0;
    do_read(12'h010, 2'd3, d, e, v);
    check("R9 engine status visible", d, 64'h0000_0001_0000_00A5);
    do_read(12'h014, 2'd2, d, e, v);
    check("R9 status upper half", d, 64'h1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_payload();
    t_header();
    t_range();
    t_doorbell();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule